// File: doc/BRIEF.md
# Prescaled Capture/Compare Timer

A 32-bit up-counter whose increment enable comes from a two-stage divider. The first stage chooses the base tick. When the external source is selected, the base tick is a rising edge of the external clock pin. When the system source is selected, the base tick is the system clock, passed either straight through or divided by sixteen. The second stage is an 8-bit prescaler with value N, which lets one enable through for every N+1 base ticks.

The block runs in one of two modes. In capture mode, a chosen edge on the capture pin copies the running count into the capture register. In compare mode, the count reaching the reference value raises an event. That event can also toggle an output pin and can restart the counter from zero.

Each event sets a sticky flag, which stays set until its acknowledge input clears it. A routing bit sends the enabled flags to either the interrupt request line or the DMA request line.

Top module: `presc_cc_timer`

## Requirements
- R1: While rst_ni is low, count_o, capture_o, cap_flag_o, ref_flag_o, out_pin_o, irq_o and dma_o are all zero.
- R2: With src_ext_i=0, div16_i=0 and prescale N on presc_i, count_o advances by exactly one for every N+1 clock cycles.
- R3: With src_ext_i=0 and div16_i=1, count_o advances by exactly one for every 16*(N+1) clock cycles.
- R4: With src_ext_i=1, ext_clk_i passes through a two-flop synchronizer. After a reset, count_o advances by one for every N+1 rising edges of ext_clk_i. It does not advance while ext_clk_i is held constant.
- R5: In capture mode (mode_cmp_i=0), a synchronized edge on cap_pin_i that matches cap_edge_i copies count_o into capture_o and sets cap_flag_o. The encoding of cap_edge_i is 2'b00 rising, 2'b01 falling, 2'b1x both. An edge that does not match is ignored.
- R6: In compare mode (mode_cmp_i=1), the increment that makes count_o equal to ref_val_i sets ref_flag_o. In compare mode, edges on cap_pin_i leave cap_flag_o unchanged.
- R7: With toggle_en_i=1 in compare mode, out_pin_o inverts on every reference hit.
- R8: With restart_i=1, the next increment after count_o equals ref_val_i loads zero. With restart_i=0, the count continues past ref_val_i.
- R9: A flag stays set until its acknowledge (cap_ack_i or ref_ack_i) is high at a clock edge. An event in the same cycle as its acknowledge leaves the flag set.
- R10: With route_dma_i=0, irq_o is the OR of (cap_flag_o AND cap_en_i) and (ref_flag_o AND ref_en_i), and dma_o is 0. With route_dma_i=1, the roles of irq_o and dma_o swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_clk_i | input | 1 | External count clock pin (asynchronous) |
| cap_pin_i | input | 1 | Capture event pin (asynchronous) |
| src_ext_i | input | 1 | 1: count external clock edges, 0: system clock |
| div16_i | input | 1 | 1: divide the system clock by 16 ahead of the prescaler |
| presc_i | input | 8 | Prescale value N, division by N+1 |
| mode_cmp_i | input | 1 | 1: reference-compare mode, 0: input-capture mode |
| cap_edge_i | input | 2 | Capture edge select |
| ref_val_i | input | 32 | Reference compare value |
| restart_i | input | 1 | Restart the count after a reference hit |
| toggle_en_i | input | 1 | Toggle out_pin_o on a reference hit |
| cap_en_i | input | 1 | Let the capture flag drive a request |
| ref_en_i | input | 1 | Let the reference flag drive a request |
| route_dma_i | input | 1 | 1: requests on dma_o, 0: on irq_o |
| cap_ack_i | input | 1 | Clear the capture flag |
| ref_ack_i | input | 1 | Clear the reference flag |
| count_o | output | 32 | Current count |
| capture_o | output | 32 | Captured count |
| out_pin_o | output | 1 | Compare output pin |
| cap_flag_o | output | 1 | Capture event flag |
| ref_flag_o | output | 1 | Reference event flag |
| irq_o | output | 1 | Interrupt request level |
| dma_o | output | 1 | DMA request level |

## Verification
A prescaler or divider phase that has gone wrong shows up as the wrong increment count over a window that spans whole periods. It can be seen within one divider period. A broken synchronizer or a broken edge selector shows up as a missing or extra capture flag, or a wrong captured value, within four cycles of the pin edge. A fault in the compare or restart path shows up within one reference period, as a count above the reference, a missing output toggle, or a flag that falls despite a same-cycle event.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned CNT_W   = 32;
  localparam int unsigned PRESC_W = 8;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_BOTH = 2'b10
  } edge_sel_e;
endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o =  sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] &  prev_q;
endmodule

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int unsigned PRESC_W = 8,
  parameter int unsigned FIX_DIV = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               src_ext_i,
  input  logic               ext_rise_i,
  input  logic               div16_i,
  input  logic [PRESC_W-1:0] presc_i,
  output logic               cnt_en_o
);
  localparam int unsigned DIV_W = $clog2(FIX_DIV);

  logic [DIV_W-1:0]   div_q;
  logic [PRESC_W-1:0] pcnt_q;
  logic               base_tick;
  logic               wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + 1'b1;
  end

  always_comb begin
    if (src_ext_i)    base_tick = ext_rise_i;
    else if (div16_i) base_tick = (div_q == DIV_W'(FIX_DIV - 1));
    else              base_tick = 1'b1;
  end

  // >= so a shrinking prescale value never strands the counter
  assign wrap     = (pcnt_q >= presc_i);
  assign cnt_en_o = base_tick & wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pcnt_q <= '0;
    else if (base_tick) pcnt_q <= wrap ? '0 : pcnt_q + 1'b1;
  end

  // R2
  presc_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(base_tick) && ($past(pcnt_q) < $past(presc_i)) |-> pcnt_q == $past(pcnt_q) + 1'b1);
endmodule

// File: rtl/tmr_event_flag.sv
module tmr_event_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic ack_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_o <= 1'b0;
    else         flag_o <= set_i | (flag_o & ~ack_i);
  end

  // R9
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o && !ack_i |=> flag_o);
endmodule

// File: rtl/presc_cc_timer.sv
module presc_cc_timer
  import tmr_pkg::*;
#(
  parameter int unsigned CW = CNT_W,
  parameter int unsigned PW = PRESC_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ext_clk_i,
  input  logic          cap_pin_i,
  input  logic          src_ext_i,
  input  logic          div16_i,
  input  logic [PW-1:0] presc_i,
  input  logic          mode_cmp_i,
  input  logic [1:0]    cap_edge_i,
  input  logic [CW-1:0] ref_val_i,
  input  logic          restart_i,
  input  logic          toggle_en_i,
  input  logic          cap_en_i,
  input  logic          ref_en_i,
  input  logic          route_dma_i,
  input  logic          cap_ack_i,
  input  logic          ref_ack_i,
  output logic [CW-1:0] count_o,
  output logic [CW-1:0] capture_o,
  output logic          out_pin_o,
  output logic          cap_flag_o,
  output logic          ref_flag_o,
  output logic          irq_o,
  output logic          dma_o
);
  logic ext_rise, ext_fall_unused;
  logic cap_rise, cap_fall;
  logic cnt_en;
  logic [CW-1:0] count_q, count_nxt, capture_q;
  logic out_q;
  logic ref_hit, cap_hit, edge_match, req;

  tmr_sync_edge #(.STAGES(2)) u_ext_sync (
    .clk_i, .rst_ni, .pin_i(ext_clk_i), .rise_o(ext_rise), .fall_o(ext_fall_unused)
  );

  tmr_sync_edge #(.STAGES(2)) u_cap_sync (
    .clk_i, .rst_ni, .pin_i(cap_pin_i), .rise_o(cap_rise), .fall_o(cap_fall)
  );

  tmr_tick_gen #(.PRESC_W(PW), .FIX_DIV(16)) u_tick (
    .clk_i, .rst_ni, .src_ext_i, .ext_rise_i(ext_rise), .div16_i,
    .presc_i, .cnt_en_o(cnt_en)
  );

  assign count_nxt = (mode_cmp_i && restart_i && count_q == ref_val_i) ? '0 : count_q + 1'b1;
  assign ref_hit   = mode_cmp_i && cnt_en && (count_nxt == ref_val_i);

  always_comb begin
    unique case (cap_edge_i)
      2'b00:   edge_match = cap_rise;
      2'b01:   edge_match = cap_fall;
      default: edge_match = cap_rise | cap_fall;
    endcase
  end
  assign cap_hit = !mode_cmp_i && edge_match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q   <= '0;
      capture_q <= '0;
      out_q     <= 1'b0;
    end else begin
      if (cnt_en)                 count_q   <= count_nxt;
      if (cap_hit)                capture_q <= count_q;
      if (ref_hit && toggle_en_i) out_q     <= ~out_q;
    end
  end

  tmr_event_flag u_cap_flag (
    .clk_i, .rst_ni, .set_i(cap_hit), .ack_i(cap_ack_i), .flag_o(cap_flag_o)
  );
  tmr_event_flag u_ref_flag (
    .clk_i, .rst_ni, .set_i(ref_hit), .ack_i(ref_ack_i), .flag_o(ref_flag_o)
  );

  assign req       = (cap_flag_o & cap_en_i) | (ref_flag_o & ref_en_i);
  assign irq_o     = req & ~route_dma_i;
  assign dma_o     = req &  route_dma_i;
  assign count_o   = count_q;
  assign capture_o = capture_q;
  assign out_pin_o = out_q;

  // R2
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(count_q) |-> (count_q == $past(count_q) + 1'b1) || (count_q == '0));
  // R7
  out_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(out_q) |-> ref_flag_o);
  // R10
  req_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({irq_o, dma_o}));
  // R5
  cap_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(capture_q) |-> !$past(mode_cmp_i));
endmodule

// File: tb/presc_cc_timer_bench.sv
module presc_cc_timer_bench;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        ext_clk_i = 0, cap_pin_i = 0, src_ext_i = 0, div16_i = 0;
  logic [7:0]  presc_i = 0;
  logic        mode_cmp_i = 0;
  logic [1:0]  cap_edge_i = 0;
  logic [31:0] ref_val_i = 0;
  logic        restart_i = 0, toggle_en_i = 0, cap_en_i = 0, ref_en_i = 0;
  logic        route_dma_i = 0, cap_ack_i = 0, ref_ack_i = 0;
  logic [31:0] count_o, capture_o;
  logic        out_pin_o, cap_flag_o, ref_flag_o, irq_o, dma_o;

  int checks = 0, errors = 0;

  always #5 clk_i = ~clk_i;

  presc_cc_timer u_presc_cc_timer (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    cyc(2);
    rst_ni = 1'b1;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    cyc(3);
    check(count_o == 0 && capture_o == 0, "R1 count/capture", count_o | capture_o, 0);
    check({cap_flag_o, ref_flag_o, out_pin_o, irq_o, dma_o} == 0, "R1 flags",
          {cap_flag_o, ref_flag_o, out_pin_o, irq_o, dma_o}, 0);
    rst_ni = 1'b1;
  endtask

  task automatic t_rate(input bit d16, input logic [7:0] n, input int win, input int exp, input string req);
    logic [31:0] a;
    src_ext_i = 0; div16_i = d16; presc_i = n;
    cyc(40);
    a = count_o;
    cyc(win);
    check(count_o - a == exp, req, count_o - a, exp);
  endtask

  task automatic t_ext();
    logic [31:0] a;
    src_ext_i = 1; presc_i = 1; mode_cmp_i = 0;
    do_reset();
    cyc(4);
    a = count_o;
    for (int i = 0; i < 6; i++) begin
      ext_clk_i = 1; cyc(4);
      ext_clk_i = 0; cyc(4);
    end
    check(count_o - a == 3, "R4 ext edges", count_o - a, 3);
    a = count_o;
    cyc(30);
    check(count_o == a, "R4 ext idle", count_o, a);
  endtask

  task automatic freeze_at(output logic [31:0] v, input int run);
    src_ext_i = 0; presc_i = 0; cyc(run);
    src_ext_i = 1; cyc(3);
    v = count_o;
  endtask

  task automatic t_capture();
    logic [31:0] v;
    mode_cmp_i = 0; cap_edge_i = 2'b00;
    do_reset();
    freeze_at(v, 20);
    cap_pin_i = 1; cyc(5);
    check(capture_o == v && cap_flag_o, "R5 rising capture", capture_o, v);
    cap_ack_i = 1; cyc(1); cap_ack_i = 0;
    cap_pin_i = 0; cyc(5);
    check(!cap_flag_o, "R5 falling ignored", cap_flag_o, 0);
    cap_edge_i = 2'b01;
    freeze_at(v, 7);
    cap_pin_i = 1; cyc(5);
    check(!cap_flag_o, "R5 rising ignored", cap_flag_o, 0);
    cap_pin_i = 0; cyc(5);
    check(capture_o == v && cap_flag_o, "R5 falling capture", capture_o, v);
    cap_ack_i = 1; cyc(1); cap_ack_i = 0;
    cap_edge_i = 2'b10;
    freeze_at(v, 9);
    cap_pin_i = 1; cyc(5);
    check(capture_o == v && cap_flag_o, "R5 both edges", capture_o, v);
    cap_ack_i = 1; cyc(1); cap_ack_i = 0;
    mode_cmp_i = 1; ref_val_i = 32'hFFFF_0000;
    cap_pin_i = 0; cyc(5); cap_pin_i = 1; cyc(5);
    check(!cap_flag_o, "R6 capture pin ignored in compare", cap_flag_o, 0);
    mode_cmp_i = 0; cap_pin_i = 0; cyc(5);
    cap_ack_i = 1; cyc(1); cap_ack_i = 0;
  endtask

  task automatic t_compare();
    logic [31:0] mx;
    logic prev;
    int tog;
    src_ext_i = 0; div16_i = 0; presc_i = 0;
    mode_cmp_i = 1; ref_val_i = 5; restart_i = 1; toggle_en_i = 1;
    do_reset();
    cyc(3);
    mx = 0; tog = 0; prev = out_pin_o;
    for (int i = 0; i < 60; i++) begin
      cyc(1);
      if (count_o > mx) mx = count_o;
      if (out_pin_o != prev) tog++;
      prev = out_pin_o;
    end
    check(mx == 5, "R8 restart bound", mx, 5);
    check(tog == 10, "R7 toggle count", tog, 10);
    check(ref_flag_o, "R6 ref flag", ref_flag_o, 1);
    while (count_o != 4) cyc(1);
    ref_ack_i = 1; cyc(1); ref_ack_i = 0;
    check(ref_flag_o, "R9 ack same cycle as event", ref_flag_o, 1);
    while (count_o != 1) cyc(1);
    ref_ack_i = 1; cyc(1); ref_ack_i = 0;
    check(!ref_flag_o, "R9 ack clears", ref_flag_o, 0);
    while (count_o != 3) cyc(1);
    check(!ref_flag_o, "R9 cleared before hit", ref_flag_o, 0);
    cyc(3);
    ref_en_i = 1; route_dma_i = 0; #1;
    check(irq_o && !dma_o, "R10 irq route", {irq_o, dma_o}, 2'b10);
    route_dma_i = 1; #1;
    check(!irq_o && dma_o, "R10 dma route", {irq_o, dma_o}, 2'b01);
    ref_en_i = 0; #1;
    check(!irq_o && !dma_o, "R10 disabled", {irq_o, dma_o}, 0);
    restart_i = 0; toggle_en_i = 0;
    do_reset();
    cyc(20);
    check(count_o > 5 && ref_flag_o, "R8 no restart passes ref", count_o, 6);
    mode_cmp_i = 0;
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_rate(1'b0, 8'd0, 40, 40, "R2 presc 0");
        t_rate(1'b0, 8'd3, 40, 10, "R2 presc 3");
        t_rate(1'b1, 8'd0, 160, 10, "R3 div16 presc 0");
        t_rate(1'b1, 8'd1, 320, 10, "R3 div16 presc 1");
        div16_i = 0;
        t_ext();
        t_capture();
        t_compare();
      end
      begin
        cyc(100000);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule